// File: doc/BRIEF.md
# Int8 Matrix Multiply-Accumulate Unit

This unit multiplies two small byte matrices and adds the 2x2 product into a running 32-bit integer tile. One operand carries a 2x8 matrix and the other an 8x2 matrix, each packed as sixteen bytes. The accumulator arrives as four 32-bit lanes. Each output lane is the matching accumulator lane plus an eight-term dot product of one row of the first matrix with one column of the second. The output replaces the old accumulator contents, so a caller that feeds `res_o` back into `acc_i` builds a running sum.

A two-bit mode input picks how the bytes are read. Both matrices can be signed or both unsigned. In the mixed mode the first matrix is unsigned and the second is signed. There is no mode with a signed first matrix and an unsigned second one. The pipeline has two stages and takes a new operation in every cycle. A qualifier travels with each operation, and the result appears a fixed two cycles later.

Top module: `mmla_tile`

## Requirements
- R1: Row i of the first matrix is bytes 8i..8i+7 of `a_i`, and column j of the second matrix is bytes 8j..8j+7 of `b_i`, with byte 0 in bits 7:0. Element (i,j) is lane 2i+j of `acc_i` and `res_o`, and lane 0 is bits 31:0.
- R2: With `mode_i` = 0, both matrices are read as two's-complement bytes.
- R3: With `mode_i` = 1, both matrices are read as unsigned bytes.
- R4: With `mode_i` = 2, the first matrix is read as unsigned bytes and the second as two's-complement bytes.
- R5: `mode_i` = 3 gives the same result as mode 0.
- R6: Every lane sum wraps modulo 2^32. There is no saturation and no flag.
- R7: `valid_o` is high exactly two cycles after `valid_i` is sampled high, and operations may be issued back to back in every cycle.
- R8: While `rst_ni` is low, `valid_o` and `res_o` are cleared to zero.
- R9: `res_o` changes only in cycles where `valid_o` is high. Otherwise it holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation qualifier |
| mode_i | input | 2 | Signedness: 0 signed, 1 unsigned, 2 unsigned-by-signed, 3 same as 0 |
| a_i | input | 128 | First matrix, 2x8 bytes |
| b_i | input | 128 | Second matrix, 8x2 bytes |
| acc_i | input | 128 | Accumulator, four 32-bit lanes |
| valid_o | output | 1 | Result qualifier |
| res_o | output | 128 | Result, four 32-bit lanes |

## Verification
The assertions assume that the adder tree never sees an input outside the byte range, so each stored dot product stays between -8*128*255 and 8*255*255. They also assume that the qualifier pipeline is only ever shifted by whole-cycle samples of `valid_i`. Inputs are driven only on the falling clock edge, and mode values are limited to two bits, so both assumptions hold. The sweeps go beyond the random stimulus: they walk a single set byte across every position, take the extreme byte patterns 0x00, 0x01, 0x7F, 0x80 and 0xFF in every mode, and start accumulator lanes next to the wrap point.

// File: rtl/mmla_pkg.sv
package mmla_pkg;
  typedef enum logic [1:0] {
    MODE_SS  = 2'd0,
    MODE_UU  = 2'd1,
    MODE_US  = 2'd2,
    MODE_SS2 = 2'd3
  } mmla_mode_e;
endpackage

// File: rtl/mmla_ext_vec.sv
// Widens each byte by one bit, sign or zero fill as selected.
module mmla_ext_vec #(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic [N*W-1:0]   vec_i,
  input  logic             sgn_i,
  output logic [N-1:0][W:0] ext_o
);
  for (genvar n = 0; n < N; n++) begin : g_lane
    assign ext_o[n] = {sgn_i & vec_i[n*W+W-1], vec_i[n*W +: W]};
  end
endmodule

// File: rtl/mmla_dot.sv
// K-term dot product of (W+1)-bit signed values through a binary adder tree.
module mmla_dot #(
  parameter int K     = 8,
  parameter int W     = 8,
  parameter int DOT_W = 21
) (
  input  logic [K-1:0][W:0] a_i,
  input  logic [K-1:0][W:0] b_i,
  output logic [DOT_W-1:0]  dot_o
);
  localparam int PROD_W = 2 * (W + 1);

  // heap layout: leaves at K..2K-1, root at 1
  logic signed [DOT_W-1:0] node [1:2*K-1];

  for (genvar k = 0; k < K; k++) begin : g_prod
    logic signed [PROD_W-1:0] ae, be, prod;
    assign ae   = {{(PROD_W-W-1){a_i[k][W]}}, a_i[k]};
    assign be   = {{(PROD_W-W-1){b_i[k][W]}}, b_i[k]};
    assign prod = ae * be;
    assign node[K+k] = {{(DOT_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  for (genvar n = 1; n < K; n++) begin : g_tree
    assign node[n] = node[2*n] + node[2*n+1];
  end

  assign dot_o = node[1];
endmodule

// File: rtl/mmla_tile.sv
module mmla_tile
  import mmla_pkg::*;
#(
  parameter int W     = 8,
  parameter int K     = 8,
  parameter int ROWS  = 2,
  parameter int COLS  = 2,
  parameter int ACC_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [1:0]                  mode_i,
  input  logic [ROWS*K*W-1:0]         a_i,
  input  logic [COLS*K*W-1:0]         b_i,
  input  logic [ROWS*COLS*ACC_W-1:0]  acc_i,
  output logic                        valid_o,
  output logic [ROWS*COLS*ACC_W-1:0]  res_o
);
  localparam int LANES   = ROWS * COLS;
  localparam int PROD_W  = 2 * (W + 1);
  localparam int DOT_W   = PROD_W + $clog2(K);
  localparam int DOT_MAX = K * ((2**W) - 1) * ((2**W) - 1);
  localparam int DOT_MIN = -(K * (2**(W-1)) * ((2**W) - 1));

  mmla_mode_e mode;
  logic       a_sgn, b_sgn;
  assign mode  = mmla_mode_e'(mode_i);
  assign a_sgn = (mode == MODE_SS) || (mode == MODE_SS2);
  assign b_sgn = (mode != MODE_UU);

  logic [ROWS*K-1:0][W:0] a_ext;
  logic [COLS*K-1:0][W:0] b_ext;

  mmla_ext_vec #(.N(ROWS*K), .W(W)) u_ext_a (.vec_i(a_i), .sgn_i(a_sgn), .ext_o(a_ext));
  mmla_ext_vec #(.N(COLS*K), .W(W)) u_ext_b (.vec_i(b_i), .sgn_i(b_sgn), .ext_o(b_ext));

  logic [LANES-1:0][DOT_W-1:0] dot;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_col
      mmla_dot #(.K(K), .W(W), .DOT_W(DOT_W)) u_dot (
        .a_i   (a_ext[i*K +: K]),
        .b_i   (b_ext[j*K +: K]),
        .dot_o (dot[i*COLS+j])
      );
    end
  end

  // stage 1: dot products and accumulator
  logic                          s1_v;
  logic [LANES-1:0][DOT_W-1:0]   s1_dot;
  logic [LANES*ACC_W-1:0]        s1_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_dot <= '0;
      s1_acc <= '0;
    end else begin
      s1_v <= valid_i;
      if (valid_i) begin
        s1_dot <= dot;
        s1_acc <= acc_i;
      end
    end
  end

  // stage 2: wrap-around accumulate
  logic [LANES*ACC_W-1:0] sum;
  for (genvar l = 0; l < LANES; l++) begin : g_sum
    assign sum[l*ACC_W +: ACC_W] = s1_acc[l*ACC_W +: ACC_W]
                                 + {{(ACC_W-DOT_W){s1_dot[l][DOT_W-1]}}, s1_dot[l]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= s1_v;
      if (s1_v) res_o <= sum;
    end
  end

  // R7
  issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_v);
  // R7
  deliver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_v |=> valid_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_v |=> (!valid_o && $stable(res_o)));

  for (genvar l = 0; l < LANES; l++) begin : g_rng
    // R4
    dot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s1_v |-> ($signed(s1_dot[l]) <= DOT_MAX && $signed(s1_dot[l]) >= DOT_MIN));
  end
endmodule

// File: tb/mmla_tile_test.sv
module mmla_tile_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic [127:0] a_i = '0, b_i = '0, acc_i = '0;
  logic         valid_o;
  logic [127:0] res_o;

  int vectors = 0;
  int fails   = 0;

  logic         hv [2];
  logic [127:0] hr [2];
  string        hq [2];
  logic [127:0] last_res;

  always #10 clk = ~clk;

  mmla_tile uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .acc_i(acc_i), .valid_o(valid_o), .res_o(res_o)
  );

  function automatic logic [127:0] ref_mmla(logic [1:0] m, logic [127:0] a,
                                            logic [127:0] b, logic [127:0] acc);
    logic [127:0] r;
    bit sa = (m == 2'd0) || (m == 2'd3);
    bit sb = (m != 2'd1);
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 2; j++) begin
        logic [31:0] s = acc[(2*i+j)*32 +: 32];
        for (int k = 0; k < 8; k++) begin
          int av = a[(8*i+k)*8 +: 8];
          int bv = b[(8*j+k)*8 +: 8];
          if (sa && av > 127) av = av - 256;
          if (sb && bv > 127) bv = bv - 256;
          s = s + 32'(av * bv);
        end
        r[(2*i+j)*32 +: 32] = s;
      end
    end
    return r;
  endfunction

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic step(input logic v, input logic [1:0] m, input logic [127:0] a,
                      input logic [127:0] b, input logic [127:0] acc, input string req);
    logic [127:0] exp_r;
    string        rq;
    @(negedge clk);
    vectors++;
    if (valid_o !== hv[1]) begin
      fails++;
      $display("FAIL R7 valid_o act=%b exp=%b", valid_o, hv[1]);
    end
    if (hv[1]) begin
      exp_r = hr[1]; rq = hq[1]; last_res = hr[1];
    end else begin
      exp_r = last_res; rq = "R9";
    end
    if (res_o !== exp_r) begin
      fails++;
      $display("FAIL %s res_o act=%h exp=%h", rq, res_o, exp_r);
    end
    hv[1] = hv[0]; hr[1] = hr[0]; hq[1] = hq[0];
    valid_i = v; mode_i = m; a_i = a; b_i = b; acc_i = acc;
    hv[0] = v; hr[0] = ref_mmla(m, a, b, acc); hq[0] = req;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] pat [5];
    pat[0] = 8'h00; pat[1] = 8'h01; pat[2] = 8'h7F; pat[3] = 8'h80; pat[4] = 8'hFF;
    hv[0] = 1'b0; hv[1] = 1'b0; hr[0] = '0; hr[1] = '0; hq[0] = ""; hq[1] = "";
    last_res = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    // R8: reset state
    if (valid_o !== 1'b0 || res_o !== '0) begin
      fails++;
      $display("FAIL R8 reset act=%b/%h exp=0/0", valid_o, res_o);
    end
    rst_ni = 1'b1;

    // R1: walk one byte of each operand across every position
    for (int p = 0; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        logic [127:0] a = '0, b = '0;
        a[p*8 +: 8] = 8'(p + 3);
        b[q*8 +: 8] = 8'(q + 5);
        step(1'b1, 2'd1, a, b, {32'd4, 32'd3, 32'd2, 32'd1}, "R1");
      end
    end

    // R2..R5: corner byte patterns in every mode
    for (int m = 0; m < 4; m++) begin
      for (int x = 0; x < 5; x++) begin
        for (int y = 0; y < 5; y++) begin
          step(1'b1, 2'(m), {16{pat[x]}}, {16{pat[y]}}, rnd128(), mode_req(2'(m)));
        end
      end
    end

    // R6: accumulators next to the wrap point
    for (int m = 0; m < 4; m++) begin
      step(1'b1, 2'(m), {16{8'h7F}}, {16{8'h7F}}, {4{32'hFFFF_FFF0}}, "R6");
      step(1'b1, 2'(m), {16{8'hFF}}, {16{8'hFF}}, {4{32'h7FFF_FFFF}}, "R6");
      step(1'b1, 2'(m), {16{8'h80}}, {16{8'h7F}}, {4{32'h8000_0000}}, "R6");
      step(1'b1, 2'(m), {16{8'h80}}, {16{8'h80}}, {4{32'hFFFF_0000}}, "R6");
    end

    // random operands with idle gaps (R7, R9)
    for (int n = 0; n < 1200; n++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0)
        step(1'b0, m, rnd128(), rnd128(), rnd128(), "R9");
      else
        step(1'b1, m, rnd128(), rnd128(), rnd128(), mode_req(m));
    end

    repeat (3) step(1'b0, 2'd0, '0, '0, '0, "R9");
    summary();
    $finish;
  end
endmodule